// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block receives asynchronous serial characters on a single line. It samples the line at sixteen times the bit rate and decides the start bit, each data bit and the stop bit by a two-out-of-three vote over the samples in the middle of the bit. The sample rate comes from the core clock divided by an 8-bit programmable divisor. A completed character goes to a holding register. The holding register raises a ready flag, reports a bad stop bit as a framing error, and reports a character that arrived while the previous one was still unread as an overrun.

The line goes through a two-stage synchronizer. A divider makes one sample strobe every `divisor + 1` clocks. A frame controller walks through four states: `ST_IDLE`, `ST_START`, `ST_DATA` and `ST_STOP`.

- `ST_IDLE` leaves for `ST_START` on the first strobe that sees the line low. The sample phase is then set to 1.
- `ST_START` goes back to `ST_IDLE` when the vote over samples 8, 9 and 10 is high. This is the false-start transition. Otherwise it moves to `ST_DATA` at the end of the bit period.
- `ST_DATA` stores one vote per bit, least significant bit first. After the last bit it moves to `ST_STOP`. There are eight data bits, or nine when the wide mode was selected at the start edge.
- `ST_STOP` votes the stop bit, hands the character to the holding register in the same cycle, and returns to `ST_IDLE`.

Software reads the character by pulsing the read strobe.

Top module: `serial_rx_vote`

## Requirements
- R1: One sample strobe occurs every `divisor+1` clocks, so a bit lasts 16*(divisor+1) clocks. Characters are received correctly with divisor values 0 and 3.
- R2: A low level on the line that does not persist over the vote of start samples 8..10 is rejected. No character is delivered, and the next real frame is received normally.
- R3: Each data bit is the majority of its samples 8, 9 and 10 (samples counted from 1 within the bit). Bits arrive least significant bit first. A single flipped sample does not change the bit, and two flipped samples do.
- R4: The stop bit is the majority of its samples 8..10. If that majority is zero, `frame_err` becomes 1 when the character is loaded into the holding register.
- R5: `frame_err` returns to 0 when a character with a good stop bit is loaded.
- R6: With `nine_bits`=1 at the start edge, nine data bits are received and bit 8 appears on `rx_data[8]`. With `nine_bits`=0, eight bits are received and `rx_data[8]` reads 0.
- R7: `rx_done` becomes 1 when a character is loaded. A one-cycle `rd_stb` pulse clears it on the following clock edge.
- R8: If a character completes while `rx_done`=1 and no read is strobed, `overrun` becomes 1 and `rx_data` keeps the unread character.
- R9: The next character that completes without an overrun is loaded, and `overrun` returns to 0.
- R10: After reset, `rx_data`=0, `rx_done`=0, `frame_err`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| divisor | input | 8 | Sample strobe divisor: one strobe every divisor+1 clocks |
| nine_bits | input | 1 | Selects nine data bits; sampled at each start edge |
| rd_stb | input | 1 | One-cycle read strobe for the holding register |
| rx_data | output | 9 | Received character |
| rx_done | output | 1 | Unread character present |
| frame_err | output | 1 | Last loaded character had a bad stop bit |
| overrun | output | 1 | A character was lost because the holding register was unread |

## Verification
The bench builds the block with its default parameters: 16x oversampling, a two-flop synchronizer and nine bits at most. It drives the divisor at run time.

With a divisor of 0, every clock is a sample, so each line cycle maps onto one numbered sample of a bit. This lets the bench flip exactly one or exactly two of the voted samples and shorten a start pulse so that it ends before the vote.

A divisor of 3 then shows that the bit period scales with the divisor.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q[0] <= 1'b1;
                else        q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q[g] <= 1'b1;
                else        q[g] <= q[g-1];
            end
        end
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // A counter past a lowered divisor wraps at once instead of running to the top.
    assign tick = (cnt_q >= divisor);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/serial_rx_vote3.sv
module serial_rx_vote3 (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic smp,
    output logic maj
);
    logic [1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  hist_q <= 2'b11;
        else if (en) hist_q <= {hist_q[0], smp};
    end

    // The two stored samples and the current sample form the vote.
    assign maj = (hist_q[1] & hist_q[0]) | (hist_q[1] & smp) | (hist_q[0] & smp);
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int MAXB = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            smp,
    input  logic            maj,
    input  logic            nine_in,
    output logic            vote_en,
    output logic            load_evt,
    output logic            stop_ok,
    output logic [MAXB-1:0] frame_data
);
    localparam int PH_W  = $clog2(OVS);
    localparam int BIT_W = $clog2(MAXB + 1);
    localparam logic [PH_W-1:0]  PH_LO   = PH_W'(OVS/2 - 1);
    localparam logic [PH_W-1:0]  PH_HI   = PH_W'(OVS/2 + 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS - 1);
    localparam logic [BIT_W-1:0] LAST9   = BIT_W'(MAXB - 1);
    localparam logic [BIT_W-1:0] LAST8   = BIT_W'(MAXB - 2);

    rx_state_e         state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [BIT_W-1:0]  bit_q;
    logic              mode9_q;
    logic [MAXB-1:0]   shreg_q;
    logic              decide, bit_end, last_bit;

    assign decide   = tick && (phase_q == PH_HI);
    assign bit_end  = tick && (phase_q == PH_LAST);
    assign last_bit = (bit_q == (mode9_q ? LAST9 : LAST8));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick && !smp)          state_d = ST_START;
            ST_START: if (decide && maj)         state_d = ST_IDLE;
                      else if (bit_end)          state_d = ST_DATA;
            ST_DATA:  if (bit_end && last_bit)   state_d = ST_STOP;
            ST_STOP:  if (decide)                state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        vote_en  = tick && (state_q != ST_IDLE) && (phase_q >= PH_LO) && (phase_q <= PH_HI);
        load_evt = (state_q == ST_STOP) && decide;
        stop_ok  = maj;
    end

    // Phase, bit index and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            bit_q   <= '0;
            mode9_q <= 1'b0;
            shreg_q <= '0;
        end else if (tick) begin
            if (state_q == ST_IDLE) begin
                if (!smp) begin
                    phase_q <= PH_W'(1);
                    mode9_q <= nine_in;
                    shreg_q <= '0;
                    bit_q   <= '0;
                end
            end else begin
                phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
                if (state_q == ST_DATA && phase_q == PH_HI)
                    shreg_q[bit_q] <= maj;
                if (state_q == ST_DATA && phase_q == PH_LAST)
                    bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign frame_data = shreg_q;
endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote #(
    parameter int DIV_W       = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAXB        = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic [DIV_W-1:0] divisor,
    input  logic             nine_bits,
    input  logic             rd_stb,
    output logic [MAXB-1:0]  rx_data,
    output logic             rx_done,
    output logic             frame_err,
    output logic             overrun
);
    logic            smp, tick, maj, vote_en, load_evt, stop_ok;
    logic [MAXB-1:0] frame_data;
    logic [MAXB-1:0] data_q;
    logic            done_q, fe_q, or_q;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(smp)
    );

    serial_rx_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    serial_rx_vote3 vote_i (
        .clk(clk), .rst_n(rst_n), .en(vote_en), .smp(smp), .maj(maj)
    );

    serial_rx_frame #(.OVS(OVS), .MAXB(MAXB)) frame_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .smp(smp), .maj(maj),
        .nine_in(nine_bits), .vote_en(vote_en), .load_evt(load_evt),
        .stop_ok(stop_ok), .frame_data(frame_data)
    );

    // Holding register: a read in the same cycle as a load frees it first.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            done_q <= 1'b0;
            fe_q   <= 1'b0;
            or_q   <= 1'b0;
        end else if (load_evt) begin
            if (done_q && !rd_stb) begin
                or_q <= 1'b1;
            end else begin
                data_q <= frame_data;
                fe_q   <= !stop_ok;
                or_q   <= 1'b0;
                done_q <= 1'b1;
            end
        end else if (rd_stb) begin
            done_q <= 1'b0;
        end
    end

    assign rx_data   = data_q;
    assign rx_done   = done_q;
    assign frame_err = fe_q;
    assign overrun   = or_q;
endmodule

// File: rtl/serial_rx_vote_chk.sv
module serial_rx_vote_chk #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_stb,
    input logic          load_evt,
    input logic          rx_done,
    input logic          frame_err,
    input logic          overrun,
    input logic [DW-1:0] rx_data
);
    assert_done_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(load_evt));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !load_evt) |=> !rx_done);

    assert_keep_on_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rx_data));

    assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_done));

    assert_fe_only_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_evt) |-> $stable(frame_err));

    assert_or_clear_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> $past(load_evt));
endmodule

bind serial_rx_vote serial_rx_vote_chk #(.DW(MAXB)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .load_evt(load_evt),
    .rx_done(rx_done), .frame_err(frame_err), .overrun(overrun), .rx_data(rx_data)
);

// File: tb/serial_rx_vote_tb_top.sv
module serial_rx_vote_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] divisor = 8'd0;
    logic       nine_bits = 1'b0;
    logic       rd_stb = 1'b0;
    logic [8:0] rx_data;
    logic       rx_done, frame_err, overrun;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    serial_rx_vote dut_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .divisor(divisor),
        .nine_bits(nine_bits), .rd_stb(rd_stb), .rx_data(rx_data),
        .rx_done(rx_done), .frame_err(frame_err), .overrun(overrun)
    );

    // Vector fields: {nine, stop level, expected frame_err, 9-bit payload}
    localparam logic [11:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b0, 9'h0A5},
        {1'b0, 1'b0, 1'b1, 9'h03C},
        {1'b0, 1'b1, 1'b0, 9'h0FF},
        {1'b0, 1'b1, 1'b0, 9'h000},
        {1'b1, 1'b1, 1'b0, 9'h155},
        {1'b1, 1'b0, 1'b1, 9'h1C3}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bits(input int n);
        int bc = 16 * (int'(divisor) + 1);
        for (int i = 0; i < n * bc; i++) begin
            @(negedge clk);
            rxd = 1'b1;
        end
    endtask

    // Slot 0 is the start bit; slot k+1 is data bit k. Glitch flips glen cycles from goff.
    task automatic send(input logic [8:0] d, input logic nine, input logic stopv,
                        input int gslot, input int goff, input int glen);
        int bc = 16 * (int'(divisor) + 1);
        int nb = nine ? 9 : 8;
        @(negedge clk);
        nine_bits = nine;
        for (int s = 0; s < nb + 2; s++) begin
            logic v;
            if (s == 0)           v = 1'b0;
            else if (s == nb + 1) v = stopv;
            else                  v = d[s-1];
            for (int c = 0; c < bc; c++) begin
                if (!(s == 0 && c == 0)) @(negedge clk);
                rxd = (s == gslot && c >= goff && c < goff + glen) ? ~v : v;
            end
        end
        @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic do_read;
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 data", 16'(rx_data), 16'h0);
        chk("R10 done", 16'(rx_done), 16'h0);
        chk("R10 fe", 16'(frame_err), 16'h0);
        chk("R10 or", 16'(overrun), 16'h0);
        rst_n = 1'b1;
        idle_bits(2);

        // Vector walk: R4 R5 R6 R7
        foreach (VEC[i]) begin
            logic [8:0] exp_d;
            exp_d = VEC[i][11] ? VEC[i][8:0] : {1'b0, VEC[i][7:0]};
            send(VEC[i][8:0], VEC[i][11], VEC[i][10], -1, 0, 0);
            idle_bits(2);
            chk("R7 done on load", 16'(rx_done), 16'h1);
            chk("R6 data", 16'(rx_data), 16'(exp_d));
            chk("R4 R5 frame_err", 16'(frame_err), 16'(VEC[i][9]));
            chk("R8 no overrun", 16'(overrun), 16'h0);
            do_read();
            chk("R7 read clears", 16'(rx_done), 16'h0);
        end

        // R2 false start: four low cycles end before the start vote
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            rxd = 1'b0;
        end
        idle_bits(3);
        chk("R2 no char after glitch", 16'(rx_done), 16'h0);
        send(9'h05A, 1'b0, 1'b1, -1, 0, 0);
        idle_bits(2);
        chk("R2 next frame data", 16'(rx_data), 16'h05A);
        do_read();

        // R3 one flipped sample (sample 9 of bit 2) leaves the bit
        send(9'h05A, 1'b0, 1'b1, 3, 8, 1);
        idle_bits(2);
        chk("R3 single flip ignored", 16'(rx_data), 16'h05A);
        do_read();

        // R3 two flipped samples (8 and 9 of bit 3) change the bit
        send(9'h000, 1'b0, 1'b1, 4, 7, 2);
        idle_bits(2);
        chk("R3 double flip wins", 16'(rx_data), 16'h008);
        do_read();

        // R8 overrun keeps the unread byte
        send(9'h011, 1'b0, 1'b1, -1, 0, 0);
        idle_bits(1);
        send(9'h022, 1'b0, 1'b0, -1, 0, 0);
        idle_bits(2);
        chk("R8 overrun set", 16'(overrun), 16'h1);
        chk("R8 data kept", 16'(rx_data), 16'h011);
        chk("R8 fe untouched", 16'(frame_err), 16'h0);
        chk("R8 done held", 16'(rx_done), 16'h1);
        do_read();

        // R9 next clean transfer clears overrun
        send(9'h033, 1'b0, 1'b1, -1, 0, 0);
        idle_bits(2);
        chk("R9 overrun cleared", 16'(overrun), 16'h0);
        chk("R9 new data", 16'(rx_data), 16'h033);
        do_read();

        // R1 slower divisor
        @(negedge clk);
        divisor = 8'd3;
        idle_bits(2);
        send(9'h096, 1'b0, 1'b1, -1, 0, 0);
        idle_bits(2);
        chk("R1 divisor 3 data", 16'(rx_data), 16'h096);
        chk("R1 divisor 3 done", 16'(rx_done), 16'h1);
        do_read();
        send(9'h169, 1'b1, 1'b1, -1, 0, 0);
        idle_bits(2);
        chk("R1 R6 divisor 3 nine", 16'(rx_data), 16'h169);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule